// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 6-bit virtual address into a 6-bit physical address. It does so by walking a two-level page table kept in a small byte-wide memory. A request carries three things: the virtual address, a read/write flag and the frame number that holds the page directory of the current process. Each process has its own directory, so switching processes only means presenting a different directory frame.

Each walk makes two reads through a synchronous memory port with one-cycle latency.

1. The walker reads the directory entry at `{directory frame, va[5:4]}`.
2. If that entry allows the access, the walker reads the page-table entry at `{entry frame, va[3:2]}`.
3. If the second entry also allows the access, the result is `{data frame, va[1:0]}`.

Directories, tables and data all occupy 4-byte frames in the same memory. A single frame therefore holds exactly one directory or one table.

The walker takes one request at a time through a valid/ready handshake. It ends every walk with a single-cycle `done` pulse, which comes with a 2-bit status and the physical address.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and both `done` and `mem_rd_en` are 0.
- R2: In the cycle after a request is accepted, `mem_rd_en` is 1 and `mem_addr` is `{req_dir_frame, req_vaddr[5:4]}`.
- R3: When the directory entry permits the access, the walker issues a second read one cycle after the first. That read is at `{entry[7:4], vaddr[3:2]}`.
- R4: When both entries permit the access, `done` is high for exactly one cycle, three cycles after the cycle of the first read. In that cycle `status` is 0 (ok) and `paddr` is `{pte[7:4], vaddr[1:0]}`.
- R5: An entry at either level whose bit 3 (valid) is 0 ends the walk with `status` 1 (invalid). This applies to reads and writes alike, and it takes precedence over the write bit.
- R6: A write that reaches an entry whose bit 2 (write allowed) is 0 ends with `status` 2 (protection), at either level. A read through the same entries succeeds.
- R7: When the directory entry faults, no second read is issued. `done` then rises two cycles after the cycle of the first read.
- R8: When a walk ends in a fault, `paddr` is 0 and `status` is never 3.
- R9: Entry bits [1:0] are reserved. Their values have no effect on the address or the status.
- R10: `req_ready` is 1 only while the walker is idle. It stays 0 from acceptance through the `done` cycle. A request that is held or changed during a walk does not alter that walk's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is presented |
| req_ready | output | 1 | The walker is idle and accepts a request |
| req_vaddr | input | 6 | Virtual address: directory index, table index, offset |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_dir_frame | input | 4 | Frame number of the current process's page directory |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 6 | Memory byte address of the entry being read |
| mem_rdata | input | 8 | Entry byte, returned one cycle after the strobe |
| done | output | 1 | One-cycle pulse that ends a walk |
| status | output | 2 | 0 ok, 1 invalid, 2 protection |
| paddr | output | 6 | Physical address (0 on a fault) |

## Verification
The hardest case to reach is a write whose directory entry forbids writes while its page-table entry is also invalid. Here the fault must come from the first level, with no second read issued. The bench builds two process address spaces whose directories and tables mix present, absent and read-only entries. It then sends both reads and writes through each combination. A separate case holds `req_valid` high with a changed address for the whole walk, to show that the hold-off leaves the first result intact.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [1:0] {
    WS_OK      = 2'd0,
    WS_INVALID = 2'd1,
    WS_PROT    = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READ_PDE = 3'd1,
    ST_READ_PTE = 3'd2,
    ST_FINAL    = 3'd3,
    ST_DONE     = 3'd4
  } walk_state_e;

endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walk_pkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int ENTRY_W = 8
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_write,
  output logic [FRAME_W-1:0] frame,
  output logic               fault,
  output walk_status_e       code
);
  localparam int V_POS = ENTRY_W - FRAME_W - 1;
  localparam int W_POS = V_POS - 1;

  function automatic logic [FRAME_W-1:0] ent_frame(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1 -: FRAME_W];
  endfunction

  function automatic logic ent_present(input logic [ENTRY_W-1:0] e);
    return e[V_POS];
  endfunction

  function automatic logic ent_writable(input logic [ENTRY_W-1:0] e);
    return e[W_POS];
  endfunction

  always_comb begin
    frame = ent_frame(entry);
    code  = WS_OK;
    if (!ent_present(entry))
      code = WS_INVALID;
    else if (is_write && !ent_writable(entry))
      code = WS_PROT;
    fault = (code != WS_OK);
  end
endmodule

// File: rtl/pt_addr_form.sv
module pt_addr_form #(
  parameter int FRAME_W = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     sel_table,
  input  logic [FRAME_W-1:0]       dir_frame,
  input  logic [FRAME_W-1:0]       table_frame,
  input  logic [IDX_W-1:0]         dir_idx,
  input  logic [IDX_W-1:0]         tbl_idx,
  output logic [FRAME_W+IDX_W-1:0] addr
);
  function automatic logic [FRAME_W+IDX_W-1:0] join_addr(
      input logic [FRAME_W-1:0] f, input logic [IDX_W-1:0] i);
    return {f, i};
  endfunction

  always_comb begin
    if (sel_table) addr = join_addr(table_frame, tbl_idx);
    else           addr = join_addr(dir_frame, dir_idx);
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        entry_fault,
  output walk_state_e state,
  output logic        ready,
  output logic        rd_en,
  output logic        done_pulse
);
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (accept) nxt = ST_READ_PDE;
      ST_READ_PDE: nxt = ST_READ_PTE;
      ST_READ_PTE: nxt = entry_fault ? ST_DONE : ST_FINAL;
      ST_FINAL:    nxt = ST_DONE;
      ST_DONE:     nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ready      = (state == ST_IDLE);
  assign rd_en      = (state == ST_READ_PDE) || ((state == ST_READ_PTE) && !entry_fault);
  assign done_pulse = (state == ST_DONE);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int IDX_W   = 2,
  parameter int ENTRY_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [3*IDX_W-1:0]       req_vaddr,
  input  logic                     req_write,
  input  logic [FRAME_W-1:0]       req_dir_frame,
  output logic                     mem_rd_en,
  output logic [FRAME_W+IDX_W-1:0] mem_addr,
  input  logic [ENTRY_W-1:0]       mem_rdata,
  output logic                     done,
  output logic [1:0]               status,
  output logic [FRAME_W+IDX_W-1:0] paddr
);
  localparam int VA_W = 3 * IDX_W;
  localparam int PA_W = FRAME_W + IDX_W;

  // request capture
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] dir_q;
  logic               accept;

  // named internal events
  walk_state_e        state;
  logic               entry_fault;
  walk_status_e       entry_code;
  logic [FRAME_W-1:0] entry_frame;
  logic               pde_check, pte_check;
  logic               pde_fault, pte_fault, walk_ok;

  // results
  walk_status_e       status_q;
  logic [PA_W-1:0]    paddr_q;

  function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] tbl_index(input logic [VA_W-1:0] va);
    return va[IDX_W +: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] page_off(input logic [VA_W-1:0] va);
    return va[IDX_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] phys(input logic [FRAME_W-1:0] f,
                                           input logic [VA_W-1:0] va);
    return {f, page_off(va)};
  endfunction

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q  <= '0;
      wr_q  <= 1'b0;
      dir_q <= '0;
    end else if (accept) begin
      va_q  <= req_vaddr;
      wr_q  <= req_write;
      dir_q <= req_dir_frame;
    end
  end

  pt_walk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .entry_fault(entry_fault),
    .state      (state),
    .ready      (req_ready),
    .rd_en      (mem_rd_en),
    .done_pulse (done)
  );

  pt_entry_check #(.FRAME_W(FRAME_W), .ENTRY_W(ENTRY_W)) u_check (
    .entry   (mem_rdata),
    .is_write(wr_q),
    .frame   (entry_frame),
    .fault   (entry_fault),
    .code    (entry_code)
  );

  pt_addr_form #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_addr (
    .sel_table  (state == ST_READ_PTE),
    .dir_frame  (dir_q),
    .table_frame(entry_frame),
    .dir_idx    (dir_index(va_q)),
    .tbl_idx    (tbl_index(va_q)),
    .addr       (mem_addr)
  );

  assign pde_check = (state == ST_READ_PTE);
  assign pte_check = (state == ST_FINAL);
  assign pde_fault = pde_check && entry_fault;
  assign pte_fault = pte_check && entry_fault;
  assign walk_ok   = pte_check && !entry_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= WS_OK;
      paddr_q  <= '0;
    end else if (pde_fault || pte_fault) begin
      status_q <= entry_code;
      paddr_q  <= '0;
    end else if (walk_ok) begin
      status_q <= WS_OK;
      paddr_q  <= phys(entry_frame, va_q);
    end
  end

  assign status = status_q;
  assign paddr  = paddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int FRAME_W = 4,
  parameter int IDX_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [3*IDX_W-1:0]       req_vaddr,
  input logic [FRAME_W-1:0]       req_dir_frame,
  input logic                     mem_rd_en,
  input logic [FRAME_W+IDX_W-1:0] mem_addr,
  input logic                     done,
  input logic [1:0]               status,
  input logic [FRAME_W+IDX_W-1:0] paddr,
  input logic                     pde_fault
);
  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_en &&
      mem_addr == {$past(req_dir_frame), $past(req_vaddr[3*IDX_W-1 -: IDX_W])}));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_not_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  a_r10_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_ok_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> ($past(mem_rd_en, 2) && $past(mem_rd_en, 3)));

  a_r7_pde_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pde_fault |=> (done && !mem_rd_en));

  a_r7_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    pde_fault |-> !mem_rd_en);

  a_r8_fault_paddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd0) |-> (paddr == '0 && status != 2'd3));
endmodule

bind pt_walker pt_walker_chk #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .req_dir_frame(req_dir_frame),
  .mem_rd_en    (mem_rd_en),
  .mem_addr     (mem_addr),
  .done         (done),
  .status       (status),
  .paddr        (paddr),
  .pde_fault    (pde_fault)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [5:0] req_vaddr = '0;
  logic       req_write = 1'b0;
  logic [3:0] req_dir_frame = '0;
  logic       mem_rd_en;
  logic [5:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic       done;
  logic [1:0] status;
  logic [5:0] paddr;

  logic [7:0] mem [64];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_dir_frame(req_dir_frame),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .status(status), .paddr(paddr)
  );

  // behavioural memory, one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  function automatic logic [7:0] ent(int frame, bit v, bit w, int rsv);
    return 8'((frame << 4) | (int'(v) << 3) | (int'(w) << 2) | (rsv & 3));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one translation, compared against the model on every clock
  task automatic walk(int dir, int va, bit wr, bit hold, string tag);
    int pde, pte, e_st, e_pa, lat, a1, a2;
    a1 = dir * 4 + (va >> 4);
    pde = mem[a1];
    a2 = 0; e_pa = 0;
    if (((pde >> 3) & 1) == 0) begin e_st = 1; lat = 2; end
    else if (wr && ((pde >> 2) & 1) == 0) begin e_st = 2; lat = 2; end
    else begin
      lat = 3;
      a2 = (pde >> 4) * 4 + ((va >> 2) & 3);
      pte = mem[a2];
      if (((pte >> 3) & 1) == 0) e_st = 1;
      else if (wr && ((pte >> 2) & 1) == 0) e_st = 2;
      else begin e_st = 0; e_pa = (pte >> 4) * 4 + (va & 3); end
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = 6'(va); req_write = wr; req_dir_frame = 4'(dir);
    for (int k = 0; k <= lat + 1; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (hold) begin req_vaddr = ~6'(va); req_write = ~wr; end
        else req_valid = 1'b0;
        chk(mem_rd_en == 1'b1 && int'(mem_addr) == a1, "R2", "first read addr",
            int'(mem_addr), a1);
      end
      if (k == 1) begin
        if (lat == 3)
          chk(mem_rd_en == 1'b1 && int'(mem_addr) == a2, "R3", "second read addr",
              int'(mem_addr), a2);
        else
          chk(mem_rd_en == 1'b0, "R7", "no second read", int'(mem_rd_en), 0);
      end
      if (k == lat && hold) req_valid = 1'b0;
      chk(done == (k == lat), (lat == 3) ? "R4" : "R7", "done timing",
          int'(done), int'(k == lat));
      chk(req_ready == (k == lat + 1), "R10", "ready during walk",
          int'(req_ready), int'(k == lat + 1));
      if (k == lat) begin
        chk(int'(status) == e_st, tag, "status", int'(status), e_st);
        chk(int'(paddr) == e_pa, (e_st != 0) ? "R8" : tag, "paddr", int'(paddr), e_pa);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    // process A: directory in frame 1
    mem[4]  = ent(3, 1, 1, 0);
    mem[5]  = ent(4, 1, 0, 0);
    mem[6]  = ent(0, 0, 1, 0);
    mem[7]  = ent(5, 1, 1, 3);
    mem[12] = ent(8, 1, 1, 0);   // table frame 3
    mem[13] = ent(9, 1, 0, 0);
    mem[14] = ent(0, 0, 1, 0);
    mem[15] = ent(10, 1, 1, 3);
    mem[16] = ent(11, 1, 1, 0);  // table frame 4
    mem[17] = ent(0, 0, 0, 0);
    mem[20] = ent(12, 1, 1, 3);  // table frame 5
    // process B: directory in frame 2
    mem[8]  = ent(6, 1, 1, 0);
    mem[24] = ent(8, 1, 0, 0);   // table frame 6
    mem[25] = ent(13, 1, 1, 0);

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_rd_en == 1'b0, "R1", "reset outputs",
        int'({req_ready, done, mem_rd_en}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_rd_en == 1'b0, "R1", "after reset",
        int'({req_ready, done, mem_rd_en}), 4);

    walk(1, 6'b00_00_01, 1'b0, 1'b0, "R4");  // read ok
    walk(1, 6'b00_00_10, 1'b1, 1'b0, "R4");  // write ok
    walk(1, 6'b00_01_11, 1'b0, 1'b0, "R6");  // read through read-only pte
    walk(1, 6'b00_01_11, 1'b1, 1'b0, "R6");  // write -> pte protection
    walk(1, 6'b00_10_00, 1'b1, 1'b0, "R5");  // pte invalid, write bit set
    walk(1, 6'b10_00_00, 1'b0, 1'b0, "R5");  // pde invalid, read
    walk(1, 6'b10_00_00, 1'b1, 1'b0, "R5");  // pde invalid beats write bit
    walk(1, 6'b01_00_01, 1'b1, 1'b0, "R6");  // pde read-only, write
    walk(1, 6'b01_01_01, 1'b1, 1'b0, "R6");  // pde protection before pte invalid
    walk(1, 6'b01_01_01, 1'b0, 1'b0, "R5");  // read reaches invalid pte
    walk(1, 6'b01_00_11, 1'b0, 1'b0, "R6");  // read via read-only pde ok
    walk(1, 6'b11_11_10, 1'b1, 1'b0, "R9");  // reserved bits set, pde
    walk(1, 6'b00_11_01, 1'b1, 1'b0, "R9");  // reserved bits set, pte
    walk(2, 6'b00_00_11, 1'b0, 1'b0, "R4");  // process B shares frame 8
    walk(2, 6'b00_00_11, 1'b1, 1'b0, "R6");  // process B read-only mapping
    walk(2, 6'b00_01_10, 1'b1, 1'b0, "R4");
    walk(2, 6'b01_00_00, 1'b0, 1'b0, "R5");
    walk(1, 6'b00_00_01, 1'b0, 1'b1, "R10"); // request held and changed
    walk(2, 6'b01_00_00, 1'b0, 1'b1, "R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R4 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule